// File: doc/BRIEF.md
# Memory Word Negate Unit

This block negates one 16-bit word held in a synchronous data memory and produces the matching condition-code flags. A request supplies a word address and the current 16-bit status word. The unit reads the word at that address and widens it by sign extension to 20 bits. It subtracts the widened value from zero and stores the low 16 bits of the difference back at the same address. It then returns the status word with its six flag bits replaced.

Two of the flags, the extension flag and the unnormalized flag, are taken from the full 20-bit difference. The other four, negative, zero, overflow and borrow, are taken from the 16-bit value that is stored. Every status bit above the flag field passes through unchanged. The unit runs one request at a time with a start/busy/done handshake. Each request goes through five steps: accept, issue read, capture data, drive the write, and signal completion.

Top module: `wordneg_unit`

## Requirements
- R1: The word stored back to the request address is the low 16 bits of zero minus the operand sign-extended to 20 bits. For example, operand 0xFF00 stores 0x0100 and operand 0x0000 stores 0x0000.
- R2: In `sr_o`, bit 3 (negative) equals bit 15 of the stored word. Bit 2 (zero) is set exactly when the stored word is 0x0000.
- R3: Bit 1 (overflow) is set only for operand 0x8000. That operand stores 0x8000 and also sets bit 3.
- R4: Bit 0 (borrow) is set for every nonzero operand and clear for operand 0x0000.
- R5: Bit 5 (extension) is set when bits 19 down to 15 of the 20-bit difference are not all equal.
- R6: Bit 4 (unnormalized) is set when bits 15 and 14 of the 20-bit difference are equal.
- R7: Bits 15 to 6 of `sr_o` equal the matching bits of `sr_i` as sampled when the request was accepted. `sr_o` changes only in the cycle in which the write is driven. For example, operand 0xFF00 with `sr_i` = 0x0300 gives `sr_o` = 0x0311.
- R8: Suppose a start is accepted at clock edge k. Then `busy_o` is high from edge k to edge k+4. `mem_we_o` is high for exactly the one cycle that begins at edge k+3. `done_o` is high for exactly the one cycle that begins at edge k+4.
- R9: While `busy_o` is high, `start_i` is ignored. `mem_addr_o` keeps the accepted address, and no second write occurs.
- R10: After reset, `busy_o`, `done_o` and `mem_we_o` are low, and `sr_o` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, accepted when not busy |
| addr_i | input | AW | Word address of the operand |
| sr_i | input | 16 | Status word to be updated |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sr_o | output | 16 | Status word with the new flags |
| mem_addr_o | output | AW | Memory address |
| mem_rdata_i | input | 16 | Memory read data, one cycle after the address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |

## Verification
The operands are chosen so that each flag is forced both ways and each pair of flags is separated:
- 0x0000 is the only operand with zero set and borrow clear.
- 0x8000 is the only operand with overflow set and the only one with the extension flag set.
- 0x0001 and 0x4000 set negative and unnormalized together.
- 0x7FFF sets negative with unnormalized clear.
- 0xFF00 and 0xC000 land on opposite sides of the unnormalized test.

Status inputs of all ones and all zeros show that the flag field is fully overwritten while the upper bits pass through. A start raised while a request is in flight, aimed at a second address, shows whether a busy request can be disturbed.

// File: rtl/wordneg_pkg.sv
package wordneg_pkg;
  localparam int FLAG_C = 0;
  localparam int FLAG_V = 1;
  localparam int FLAG_Z = 2;
  localparam int FLAG_N = 3;
  localparam int FLAG_U = 4;
  localparam int FLAG_E = 5;
  localparam int NFLAGS = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CAPT,
    ST_WRITE,
    ST_DONE
  } seq_t;

  // packed msb..lsb so that the struct lines up with status bits 5..0
  typedef struct packed {
    logic e;
    logic u;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/wordneg_flags.sv
module wordneg_flags
  import wordneg_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 4
) (
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] result_o,
  output ccr_t              flags_o
);
  localparam int EXT_W = DATA_W + GUARD_W;

  logic [EXT_W-1:0]   widened;
  logic [EXT_W-1:0]   diff;
  logic [GUARD_W:0]   top_bits;

  always_comb begin
    widened  = {{GUARD_W{operand_i[DATA_W-1]}}, operand_i};
    diff     = '0 - widened;
    result_o = diff[DATA_W-1:0];
    top_bits = diff[EXT_W-1:DATA_W-1];

    flags_o.e = !((&top_bits) || (~|top_bits));
    flags_o.u = (diff[DATA_W-1] == diff[DATA_W-2]);
    flags_o.n = result_o[DATA_W-1];
    flags_o.z = ~|result_o;
    // 0 - x overflows only when x and the result are both negative
    flags_o.v = operand_i[DATA_W-1] & result_o[DATA_W-1];
    flags_o.c = |operand_i;
  end
endmodule

// File: rtl/wordneg_ctrl.sv
module wordneg_ctrl
  import wordneg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic accept_o,
  output logic capt_o,
  output logic wr_o,
  output logic busy_o,
  output logic done_o,
  output logic we_o
);
  seq_t st;

  assign accept_o = (st == ST_IDLE) && start_i;
  assign capt_o   = (st == ST_CAPT);
  assign wr_o     = (st == ST_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      we_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      we_o   <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          st     <= ST_READ;
          busy_o <= 1'b1;
        end
        ST_READ:  st <= ST_CAPT;
        ST_CAPT:  st <= ST_WRITE;
        ST_WRITE: begin
          st   <= ST_DONE;
          we_o <= 1'b1;
        end
        ST_DONE: begin
          st     <= ST_IDLE;
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wordneg_unit.sv
module wordneg_unit
  import wordneg_pkg::*;
#(
  parameter int AW   = 8,
  parameter int SR_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [SR_W-1:0] sr_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [SR_W-1:0] sr_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic [15:0]     mem_rdata_i,
  output logic [15:0]     mem_wdata_o,
  output logic            mem_we_o
);
  localparam int DATA_W = 16;
  localparam int KEEP_W = SR_W - NFLAGS;

  logic              accept, capt, wr;
  logic [SR_W-1:0]   sr_q;
  logic [DATA_W-1:0] op_q;
  logic [DATA_W-1:0] neg_res;
  ccr_t              neg_flags;

  wordneg_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .accept_o (accept),
    .capt_o   (capt),
    .wr_o     (wr),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .we_o     (mem_we_o)
  );

  wordneg_flags #(.DATA_W(DATA_W), .GUARD_W(4)) u_flags (
    .operand_i (op_q),
    .result_o  (neg_res),
    .flags_o   (neg_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr_o  <= '0;
      sr_q        <= '0;
      op_q        <= '0;
      mem_wdata_o <= '0;
      sr_o        <= '0;
    end else begin
      if (accept) begin
        mem_addr_o <= addr_i;
        sr_q       <= sr_i;
      end
      if (capt) op_q <= mem_rdata_i;
      if (wr) begin
        mem_wdata_o <= neg_res;
        sr_o        <= {sr_q[SR_W-1:NFLAGS], neg_flags};
      end
    end
  end

  if (KEEP_W < 0) begin : g_bad_width
    initial $error("status word narrower than flag field");
  end
endmodule

// File: rtl/wordneg_chk.sv
module wordneg_chk
  import wordneg_pkg::*;
#(
  parameter int AW   = 8,
  parameter int SR_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            busy_o,
  input logic            done_o,
  input logic            mem_we_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic [15:0]     mem_wdata_o,
  input logic [SR_W-1:0] sr_o
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R8
  AST_WE_THEN_DONE: assert property (@(posedge clk) disable iff (rst) mem_we_o |=> (done_o && !mem_we_o)); // R8
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst) !busy_o |-> !mem_we_o); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst) (busy_o && $past(busy_o)) |-> $stable(mem_addr_o)); // R9
  AST_NZ_MATCH: assert property (@(posedge clk) disable iff (rst) mem_we_o |-> (sr_o[FLAG_N] == mem_wdata_o[15] && sr_o[FLAG_Z] == (mem_wdata_o == 16'h0000))); // R2
  AST_V_ONLY_MIN: assert property (@(posedge clk) disable iff (rst) (mem_we_o && sr_o[FLAG_V]) |-> (mem_wdata_o == 16'h8000 && sr_o[FLAG_N])); // R3
  AST_SR_HOLD: assert property (@(posedge clk) disable iff (rst) !mem_we_o |-> $stable(sr_o)); // R7
endmodule

bind wordneg_unit wordneg_chk #(.AW(AW), .SR_W(SR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .sr_o        (sr_o)
);

// File: tb/wordneg_unit_test.sv
`timescale 1ns/1ps
module wordneg_unit_test;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [15:0]   sr_i = '0;
  logic          busy_o, done_o, mem_we_o;
  logic [15:0]   sr_o, mem_wdata_o;
  logic [15:0]   mem_rdata_i;
  logic [AW-1:0] mem_addr_o;

  logic          tb_we = 1'b0;
  logic [AW-1:0] tb_addr = '0;
  logic [15:0]   tb_data = '0;
  logic [15:0]   mem [0:(1<<AW)-1];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wordneg_unit #(.AW(AW), .SR_W(16)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .sr_i(sr_i),
    .busy_o(busy_o), .done_o(done_o), .sr_o(sr_o), .mem_addr_o(mem_addr_o),
    .mem_rdata_i(mem_rdata_i), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o)
  );

  always_ff @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    else if (tb_we) mem[tb_addr] <= tb_data;
    mem_rdata_i <= mem[mem_addr_o];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // cycle model: phase 0 idle, 1..4 busy, 4 write, 5 done pulse
  int            phase = 0;
  logic [AW-1:0] model_addr = '0;

  always @(posedge clk) begin
    if (rst) phase = 0;
    else if ((phase == 0 || phase == 5) && start_i) begin
      phase = 1;
      model_addr = addr_i;
    end else if (phase == 5) phase = 0;
    else if (phase > 0) phase = phase + 1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(busy_o === (phase >= 1 && phase <= 4), "R8 busy", {31'd0, busy_o}, phase);
      check(mem_we_o === (phase == 4), "R8 write enable", {31'd0, mem_we_o}, phase);
      check(done_o === (phase == 5), "R8 done", {31'd0, done_o}, phase);
      if (phase >= 1 && phase <= 4)
        check(mem_addr_o === model_addr, "R9 address", {24'd0, mem_addr_o}, {24'd0, model_addr});
    end
  end

  function automatic logic [15:0] exp_sr(input logic [15:0] op, input logic [15:0] sr_in);
    int          r;
    logic [19:0] r20;
    logic [5:0]  f;
    r   = -$signed({{16{op[15]}}, op});
    r20 = r[19:0];
    f[5] = (r > 32767) || (r < -32768);
    f[4] = (r20[15] == r20[14]);
    f[3] = r20[15];
    f[2] = (r20[15:0] == 16'h0000);
    f[1] = (op == 16'h8000);
    f[0] = (op != 16'h0000);
    return {sr_in[15:6], f};
  endfunction

  task automatic run_op(input logic [AW-1:0] a, input logic [15:0] val,
                        input logic [15:0] sr_in, input bit poke_busy,
                        input logic [AW-1:0] a2);
    logic [15:0] e_sr, e_w;
    int          waited;
    @(negedge clk);
    tb_we = 1'b1; tb_addr = a; tb_data = val;
    @(negedge clk);
    tb_we = 1'b0;
    start_i = 1'b1; addr_i = a; sr_i = sr_in;
    @(negedge clk);
    start_i = 1'b0;
    if (poke_busy) begin
      start_i = 1'b1; addr_i = a2; sr_i = 16'h0000;
      @(negedge clk);
      @(negedge clk);
      start_i = 1'b0;
    end
    waited = 0;
    while (!done_o && waited < 40) begin
      @(negedge clk);
      waited++;
    end
    check(done_o === 1'b1, "R8 completion", {31'd0, done_o}, 1);
    e_w  = 16'(-$signed({{16{val[15]}}, val}));
    e_sr = exp_sr(val, sr_in);
    check(mem[a] === e_w, "R1 stored word", {16'd0, mem[a]}, {16'd0, e_w});
    check(sr_o[3:2] === e_sr[3:2], "R2 N/Z", {30'd0, sr_o[3:2]}, {30'd0, e_sr[3:2]});
    check(sr_o[1] === e_sr[1], "R3 overflow", {31'd0, sr_o[1]}, {31'd0, e_sr[1]});
    check(sr_o[0] === e_sr[0], "R4 borrow", {31'd0, sr_o[0]}, {31'd0, e_sr[0]});
    check(sr_o[5] === e_sr[5], "R5 extension", {31'd0, sr_o[5]}, {31'd0, e_sr[5]});
    check(sr_o[4] === e_sr[4], "R6 unnormalized", {31'd0, sr_o[4]}, {31'd0, e_sr[4]});
    check(sr_o[15:6] === e_sr[15:6], "R7 upper bits", {16'd0, sr_o}, {16'd0, e_sr});
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0 && mem_we_o === 1'b0, "R10 reset controls",
          {29'd0, busy_o, done_o, mem_we_o}, 0);
    check(sr_o === 16'h0000, "R10 reset status", {16'd0, sr_o}, 0);
    rst = 1'b0;
    @(negedge clk);

    run_op(8'h20, 16'hFF00, 16'h0300, 1'b0, 8'h00);
    check(sr_o === 16'h0311, "R7 worked example", {16'd0, sr_o}, 32'h0311);
    run_op(8'h21, 16'h0000, 16'hFFFF, 1'b0, 8'h00);
    run_op(8'h22, 16'h8000, 16'h0000, 1'b0, 8'h00);
    check(sr_o[5:0] === 6'h2B, "R3 minimum operand flags", {26'd0, sr_o[5:0]}, 32'h2B);
    run_op(8'h23, 16'h0001, 16'hA5C0, 1'b0, 8'h00);
    run_op(8'h24, 16'h7FFF, 16'h5A3F, 1'b0, 8'h00);
    run_op(8'h25, 16'h4000, 16'h0000, 1'b0, 8'h00);
    run_op(8'h26, 16'hC000, 16'hFFC0, 1'b0, 8'h00);

    // start while busy aimed at another address must leave it untouched
    @(negedge clk);
    tb_we = 1'b1; tb_addr = 8'h40; tb_data = 16'h1234;
    @(negedge clk);
    tb_we = 1'b0;
    run_op(8'h30, 16'h0005, 16'h0100, 1'b1, 8'h40);
    check(mem[8'h40] === 16'h1234, "R9 ignored start", {16'd0, mem[8'h40]}, 32'h1234);
    repeat (6) @(negedge clk);
    check(busy_o === 1'b0, "R9 no second request", {31'd0, busy_o}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule